// File: doc/BRIEF.md
# Serial Flash Continuous-Read Master

This block is the host side of a serial peripheral link to a page-organised flash memory. On a start request it selects the memory, sends the continuous array read command (opcode 0xE8), then a 24-bit address built from a page number and a byte offset. Next come 32 don't-care bits, after which the memory streams data for as long as the clock keeps running. Each received byte is presented on a parallel output with a one-cycle valid strobe. The address follows one of two page layouts: 528 bytes per page with a 10-bit offset, or 512 bytes per page with a 9-bit offset.

The serial clock is made from the system clock. Each half period lasts `HALF_DIV` system cycles. The idle level of the serial clock is chosen per burst, which covers SPI mode 0 (idle low) and mode 3 (idle high). The burst runs until the stop input is seen. The master then completes the byte in progress, releases chip select and returns to idle.

Top module: `sfr_cont_read`

## Requirements
- R1: After reset and whenever no burst is running, `cs_n_o` is 1, `busy_o` is 0, `rd_valid_o` is 0 and `sck_o` follows `idle_high_i`.
- R2: A `start_i` pulse while idle drives `cs_n_o` to 0 on the following cycle. `cs_n_o` stays 0 through command, address, dummy and data bits until the burst ends. `start_i` asserted while busy has no effect on the command that is sent.
- R3: The first 8 bits shifted out on `mosi_o` are the opcode 0xE8, sent most significant bit first.
- R4: With `mode512_i` = 0, the next 24 bits are {1'b0, page_i[12:0], offset_i[9:0]}, sent MSB first.
- R5: With `mode512_i` = 1, the next 24 bits are {2'b00, page_i[12:0], offset_i[8:0]}. offset_i[9] is ignored.
- R6: The 32 bits after the address are all 0, and `mosi_o` stays 0 for the whole data phase. No further address is sent.
- R7: `miso_i` is sampled on each rising edge of `sck_o`. From the 65th rising edge onward, every group of 8 rising edges forms one byte, MSB first. Each byte appears on `rd_data_o` with `rd_valid_o` high for exactly one cycle. `mosi_o` changes only while `sck_o` is low.
- R8: When `cs_n_o` falls, `sck_o` sits at the level `idle_high_i` had at start. 0 gives mode 0 (first edge rising) and 1 gives mode 3 (first edge falling).
- R9: A `stop_i` pulse during the data phase ends the burst after the byte in progress completes. A pulse during the command/address/dummy phase ends it after exactly one data byte. `cs_n_o` then returns to 1.
- R10: While `cs_n_o` is 0, every high phase of `sck_o` lasts `HALF_DIV` system clock cycles.
- R11: When a burst ends, `sck_o` is back at its burst's idle level as `cs_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a read burst (used only while idle) |
| page_i | input | 13 | Page number |
| offset_i | input | 10 | Byte offset within the page (bit 9 unused in 512 mode) |
| mode512_i | input | 1 | 1 = 512-byte page layout, 0 = 528-byte layout |
| idle_high_i | input | 1 | Serial clock idle level: 0 = mode 0, 1 = mode 3 |
| stop_i | input | 1 | Request end of burst at the next byte boundary |
| busy_o | output | 1 | A burst is in progress |
| rd_data_o | output | 8 | Last received data byte |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| cs_n_o | output | 1 | Chip select to the flash, active low |
| sck_o | output | 1 | Serial clock to the flash |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest cases to reach are the ends of the stream: a stop that arrives while the header is still shifting, and a data stream that runs past the end of a page and past the last page. The bench uses a cycle-sampled flash model that returns a pattern computed from the linear byte position. A burst that starts near the end of page 8191 therefore checks page crossing and wrap together. In a separate burst, a stop pulse is issued immediately after start, and that burst must deliver exactly one byte. In another burst, a start pulse with a different page is applied mid-burst, and the header captured by the model must still match the first request.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_END  = 2'd2
   } sfr_state_t;

   localparam logic [7:0] SFR_CMD_CONT_READ = 8'hE8;
   localparam int         SFR_BYTE_W        = 8;
endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("sfr_tick_gen: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_every_cycle
         assign tick = en;
      end else begin : g_counter
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!en)           cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = en && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sfr_addr_pack.sv
module sfr_addr_pack #(
   parameter int PAGE_W = 13,
   parameter int OFF_W  = 10,
   parameter int ADDR_W = 24
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic              mode512_i,
   output logic [ADDR_W-1:0] addr_o
);
   generate
      if (PAGE_W + OFF_W > ADDR_W) begin : g_bad_width
         $error("sfr_addr_pack: page and offset do not fit the address field");
      end
      if (OFF_W < 2) begin : g_bad_off
         $error("sfr_addr_pack: offset width too small");
      end
   endgenerate

   // 528-byte layout uses the full offset, 512-byte layout drops its top bit;
   // upper unused address bits are zero in both.
   logic [ADDR_W-1:0] addr_std;
   logic [ADDR_W-1:0] addr_bin;

   always_comb begin
      addr_std = ADDR_W'({page_i, offset_i});
      addr_bin = ADDR_W'({page_i, offset_i[OFF_W-2:0]});
      addr_o   = mode512_i ? addr_bin : addr_std;
   end
endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb_o
);
   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= load_val;
      else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign msb_o = sr_q[W-1];
endmodule

// File: rtl/sfr_rx_shift.sv
module sfr_rx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sample,
   input  logic         din,
   output logic [W-1:0] word_next
);
   logic [W-2:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q <= '0;
      else if (sample) hist_q <= word_next[W-2:0];
   end

   assign word_next = {hist_q, din};
endmodule

// File: rtl/sfr_cont_read.sv
module sfr_cont_read
   import sfr_pkg::*;
#(
   parameter int HALF_DIV    = 2,
   parameter int PAGE_W      = 13,
   parameter int OFF_W       = 10,
   parameter int ADDR_BYTES  = 3,
   parameter int DUMMY_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic              mode512_i,
   input  logic              idle_high_i,
   input  logic              stop_i,
   output logic              busy_o,
   output logic [7:0]        rd_data_o,
   output logic              rd_valid_o,
   output logic              cs_n_o,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i
);
   localparam int ADDR_W  = SFR_BYTE_W * ADDR_BYTES;
   localparam int DUMMY_W = SFR_BYTE_W * DUMMY_BYTES;
   localparam int HDR_W   = SFR_BYTE_W + ADDR_W + DUMMY_W;
   localparam int HCW     = $clog2(HDR_W + 1);
   localparam int BCW     = $clog2(SFR_BYTE_W);
   localparam logic [HCW-1:0] HDR_LAST  = HCW'(HDR_W - 1);
   localparam logic [BCW-1:0] BYTE_LAST = BCW'(SFR_BYTE_W - 1);

   generate
      if (ADDR_BYTES < 1 || DUMMY_BYTES < 0) begin : g_bad_hdr
         $error("sfr_cont_read: bad header byte counts");
      end
   endgenerate

   sfr_state_t     state_q;
   logic           cs_n_q, sck_q, idle_lvl_q, stop_pend_q;
   logic           in_data_q, shift_pend_q, rd_valid_q;
   logic [HCW-1:0] hdr_cnt_q;
   logic [BCW-1:0] bit_cnt_q;
   logic [7:0]     rd_data_q;

   logic              tick, rise, fall, load_tx, shift_tx, byte_done;
   logic [ADDR_W-1:0] addr_w;
   logic [7:0]        rx_next;

   sfr_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state_q != ST_IDLE),
      .tick  (tick)
   );

   sfr_addr_pack #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_addr (
      .page_i    (page_i),
      .offset_i  (offset_i),
      .mode512_i (mode512_i),
      .addr_o    (addr_w)
   );

   assign rise      = tick && (state_q == ST_RUN) && !sck_q;
   assign fall      = tick && (state_q == ST_RUN) &&  sck_q;
   assign load_tx   = (state_q == ST_IDLE) && start_i;
   assign shift_tx  = fall && shift_pend_q;
   assign byte_done = rise && in_data_q && (bit_cnt_q == BYTE_LAST);

   sfr_tx_shift #(.W(HDR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_tx),
      .load_val ({SFR_CMD_CONT_READ, addr_w, {DUMMY_W{1'b0}}}),
      .shift    (shift_tx),
      .msb_o    (mosi_o)
   );

   sfr_rx_shift #(.W(SFR_BYTE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (rise),
      .din       (miso_i),
      .word_next (rx_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cs_n_q       <= 1'b1;
         sck_q        <= 1'b0;
         idle_lvl_q   <= 1'b0;
         stop_pend_q  <= 1'b0;
         in_data_q    <= 1'b0;
         shift_pend_q <= 1'b0;
         hdr_cnt_q    <= '0;
         bit_cnt_q    <= '0;
         rd_valid_q   <= 1'b0;
         rd_data_q    <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               sck_q  <= idle_high_i;
               cs_n_q <= 1'b1;
               if (start_i) begin
                  idle_lvl_q   <= idle_high_i;
                  cs_n_q       <= 1'b0;
                  stop_pend_q  <= 1'b0;
                  in_data_q    <= 1'b0;
                  shift_pend_q <= 1'b0;
                  hdr_cnt_q    <= '0;
                  bit_cnt_q    <= '0;
                  state_q      <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (stop_i) stop_pend_q <= 1'b1;
               if (tick)   sck_q <= ~sck_q;
               if (rise) begin
                  shift_pend_q <= 1'b1;
                  if (!in_data_q) begin
                     hdr_cnt_q <= hdr_cnt_q + 1'b1;
                     if (hdr_cnt_q == HDR_LAST) in_data_q <= 1'b1;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
               if (fall) shift_pend_q <= 1'b0;
               if (byte_done) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= rx_next;
                  if (stop_pend_q || stop_i) state_q <= ST_END;
               end
            end
            ST_END: begin
               if (tick) begin
                  cs_n_q  <= 1'b1;
                  sck_q   <= idle_lvl_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign cs_n_o     = cs_n_q;
   assign sck_o      = sck_q;
   assign rd_valid_o = rd_valid_q;
   assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/sfr_cont_read_chk.sv
module sfr_cont_read_chk (
   input logic clk,
   input logic rst_n,
   input logic idle_high_i,
   input logic busy_o,
   input logic rd_valid_o,
   input logic cs_n_o,
   input logic sck_o,
   input logic mosi_o
);
   assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !rd_valid_o));

   assert_valid_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !cs_n_o);

   assert_valid_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |=> !rd_valid_o);

   assert_mosi_quiet_when_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && $past(!cs_n_o) && sck_o && $past(sck_o)) |-> $stable(mosi_o));

   assert_idle_level_at_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (sck_o == $past(idle_high_i)));
endmodule

bind sfr_cont_read sfr_cont_read_chk u_sfr_cont_read_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .idle_high_i (idle_high_i),
   .busy_o      (busy_o),
   .rd_valid_o  (rd_valid_o),
   .cs_n_o      (cs_n_o),
   .sck_o       (sck_o),
   .mosi_o      (mosi_o)
);

// File: tb/sfr_cont_read_bench.sv
module sfr_cont_read_bench;
   localparam int HALF_DIV = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, mode512_i = 1'b0, idle_high_i = 1'b0, stop_i = 1'b0;
   logic [12:0] page_i = '0;
   logic [9:0]  offset_i = '0;
   logic        busy_o, rd_valid_o, cs_n_o, sck_o, mosi_o;
   logic [7:0]  rd_data_o;
   logic        miso_i = 1'b0;

   sfr_cont_read #(.HALF_DIV(HALF_DIV)) u_sfr_cont_read (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
      .offset_i(offset_i), .mode512_i(mode512_i), .idle_high_i(idle_high_i),
      .stop_i(stop_i), .busy_o(busy_o), .rd_data_o(rd_data_o),
      .rd_valid_o(rd_valid_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
      .mosi_o(mosi_o), .miso_i(miso_i)
   );

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Memory pattern, from linear position with page roll-over and page wrap.
   logic        m_512;
   logic [12:0] m_page;
   logic [9:0]  m_off;

   function automatic logic [7:0] mem_byte(input logic m, input logic [12:0] pg,
                                           input logic [9:0] off, input int j);
      int psz, pos, p, b;
      psz = m ? 512 : 528;
      pos = (m ? int'(off[8:0]) : int'(off)) + j;
      p   = (int'(pg) + pos / psz) % 8192;
      b   = pos % psz;
      return 8'(((p * 29) + (b * 7) + 60) ^ (b >> 3));
   endfunction

   // Flash model and monitors, sampled between system clock edges.
   logic [63:0] hdr_cap = '0;
   int  nrise = 0;
   int  mosi_nz = 0;
   int  hi_cnt = 0;
   int  hi_err = 0;
   int  got_cnt = 0;
   logic prev_sck = 1'b0, prev_cs = 1'b1;

   always @(negedge clk) begin
      if (prev_cs && !cs_n_o) begin
         nrise   = 0;
         hdr_cap = '0;
      end else if (!cs_n_o && !prev_sck && sck_o) begin
         if (nrise < 64) hdr_cap = {hdr_cap[62:0], mosi_o};
         else if (mosi_o) mosi_nz++;
         nrise++;
      end else if (!cs_n_o && prev_sck && !sck_o && nrise >= 64) begin
         miso_i <= mem_byte(m_512, m_page, m_off, (nrise - 64) / 8)[7 - ((nrise - 64) % 8)];
      end
      // R10: high phase length
      if (cs_n_o) hi_cnt = 0;
      else if (sck_o) hi_cnt++;
      else begin
         if (hi_cnt != 0 && hi_cnt != HALF_DIV) hi_err++;
         hi_cnt = 0;
      end
      prev_sck = sck_o;
      prev_cs  = cs_n_o;
   end

   // Scoreboard monitor (R7)
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         got_cnt++;
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", 64'(rd_data_o), 64'h0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_data_o == e, "R7 data byte", 64'(rd_data_o), 64'(e));
         end
      end
   end

   task automatic run_burst(input logic ih, input logic m, input logic [12:0] pg,
                            input logic [9:0] off, input int nb, input bit poke);
      int got0, hi0, nz0, t;
      logic [23:0] exp_addr;
      m_512 = m; m_page = pg; m_off = off;
      for (int j = 0; j < nb; j++) exp_q.push_back(mem_byte(m, pg, off, j));
      got0 = got_cnt; hi0 = hi_err; nz0 = mosi_nz;
      exp_addr = m ? {2'b00, pg, off[8:0]} : {1'b0, pg, off};
      @(negedge clk);
      idle_high_i = ih; mode512_i = m; page_i = pg; offset_i = off;
      @(negedge clk);
      chk(sck_o == ih, "R1 idle level before start", 64'(sck_o), 64'(ih));
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(cs_n_o == 1'b0, "R2 select after start", 64'(cs_n_o), 64'h0);
      chk(sck_o == ih, "R8 clock level at select", 64'(sck_o), 64'(ih));
      if (nb == 1) begin
         stop_i = 1'b1;            // R9: stop during header
         @(negedge clk);
         stop_i = 1'b0;
      end else begin
         if (poke) begin
            repeat (20) @(negedge clk);
            page_i = ~pg; start_i = 1'b1;   // R2: ignored while busy
            repeat (3) @(negedge clk);
            start_i = 1'b0; page_i = pg;
         end
         t = 0;
         while (got_cnt - got0 < nb - 1 && t < 20000) begin @(negedge clk); t++; end
         stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
      end
      t = 0;
      while (busy_o && t < 20000) begin
         chk(cs_n_o == 1'b0 || !busy_o, "R2 select held", 64'(cs_n_o), 64'h0);
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      chk(hdr_cap[63:56] == 8'hE8, "R3 opcode", 64'(hdr_cap[63:56]), 64'hE8);
      chk(hdr_cap[55:32] == exp_addr, m ? "R5 address 512" : "R4 address 528",
          64'(hdr_cap[55:32]), 64'(exp_addr));
      chk(hdr_cap[31:0] == 32'h0, "R6 dummy bits", 64'(hdr_cap[31:0]), 64'h0);
      chk(mosi_nz == nz0, "R6 mosi quiet in data", 64'(mosi_nz - nz0), 64'h0);
      chk(got_cnt - got0 == nb, "R9 byte count at stop", 64'(got_cnt - got0), 64'(nb));
      chk(exp_q.size() == 0, "R7 all bytes seen", 64'(exp_q.size()), 64'h0);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R9 deselect after stop", 64'({cs_n_o, busy_o}), 64'h2);
      chk(sck_o == ih, "R11 idle level after burst", 64'(sck_o), 64'(ih));
      chk(hi_err == hi0, "R10 high phase length", 64'(hi_err - hi0), 64'h0);
      exp_q.delete();
   endtask

   bit done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1, "R1 reset cs", 64'(cs_n_o), 64'h1);
      chk(busy_o == 1'b0 && rd_valid_o == 1'b0, "R1 reset busy/valid", 64'({busy_o, rd_valid_o}), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sck_o == 1'b0, "R1 idle sck mode 0", 64'(sck_o), 64'h0);
      run_burst(1'b0, 1'b0, 13'd5,    10'd100,   6, 1'b1);  // mode 0, 528
      run_burst(1'b1, 1'b0, 13'd8191, 10'd526,   5, 1'b0);  // mode 3, page end + wrap
      run_burst(1'b0, 1'b1, 13'd300,  10'h3FE,   4, 1'b0);  // 512, bit 9 ignored
      run_burst(1'b1, 1'b1, 13'd1,    10'd0,     1, 1'b0);  // stop in header
      run_burst(1'b1, 1'b0, 13'd4096, 10'd527,   3, 1'b0);  // mode 3, last 528 byte
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule